// File: doc/BRIEF.md
# Register-Driven SPI Master with Sticky Status Flags

This block is a serial peripheral interface master controlled through a small register port. The host sets a configuration word (master enable, clock polarity, clock phase, word length, fault detection enable, interrupt enable and an 8-bit divider). A write of a data word then starts a full-duplex exchange of 8 or 16 bits. The word is shifted out most significant bit first, and the reply is shifted into the low end of the same register. When the exchange ends, the shifted word is copied to a receive buffer, which the host reads at any time.

The transmit side has a single buffer. A data write that arrives during an exchange is dropped and leaves a sticky collision mark. Four sticky event flags (done, collision, overrun, fault) stay set until the host clears them with a masked clear write. Any set flag raises one interrupt line while the interrupt enable bit is 1. A low level on the select input, while fault detection and master mode are both on, is treated as a competing master. It ends the exchange at once and switches master mode off.

Top module: `spi_ctl_master`

## Requirements
- R1: A `data_wr` pulse while master mode is on and no exchange is running starts an exchange, and `stat_busy` reads 1 from the following cycle.
- R2: Each half period of `sck` lasts D+1 core cycles, where D is the divider value. `stat_busy` stays 1 for exactly 2·N·(D+1) cycles, where N is 8 when `cfg_wide`=0 and 16 when `cfg_wide`=1.
- R3: `mosi` carries the written word most significant bit first (bit 7 in 8-bit mode, bit 15 in 16-bit mode). When the exchange ends, `rx_data` holds the N bits received on `miso`, the first received bit being the most significant. In 8-bit mode bits 15:8 read 0.
- R4: At the end of each exchange `stat_done` becomes 1 and stays 1 until it is cleared.
- R5: A `data_wr` while `stat_busy`=1 sets `stat_coll`. It leaves the running exchange unchanged, both on `mosi` and in `rx_data`.
- R6: An exchange that ends while `stat_done` is already 1 sets `stat_ovr`, and `rx_data` still takes the new word.
- R7: `irq` is 1 exactly when `cfg_irq_en`=1 and at least one of the four event flags is 1.
- R8: While idle, `sck` rests at `cfg_cpol`. With `cfg_cpha`=0, `miso` is sampled on leading edges and `mosi` changes on trailing edges. With `cfg_cpha`=1, `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R9: `sel_n` sampled low while `cfg_fault_en`=1 and master mode is on does four things: it stops any exchange (`stat_busy` 0 next cycle, `rx_data` unchanged), clears `stat_mst_en`, returns `sck` to idle and sets `stat_fault`. With `cfg_fault_en`=0, `sel_n` has no effect.
- R10: A `data_wr` while master mode is off starts nothing and sets no flag.
- R11: After reset, `stat_busy`, `stat_mst_en`, all four flags, `irq`, `sck` and `rx_data` are 0.
- R12: A `clr_wr` pulse clears the flags whose bits are set in `clr_mask` (bit 0 done, bit 1 collision, bit 2 overrun, bit 3 fault) and leaves the others unchanged. An event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mst_en | input | 1 | Master mode enable |
| cfg_cpol | input | 1 | Idle level of sck |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_wide | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| cfg_fault_en | input | 1 | Enables fault detection on sel_n |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_div | input | 8 | Divider value D |
| clr_wr | input | 1 | Flag clear strobe |
| clr_mask | input | 4 | Flags to clear |
| data_wr | input | 1 | Data write strobe |
| data_in | input | 16 | Word to transmit |
| rx_data | output | 16 | Receive buffer |
| stat_busy | output | 1 | Exchange in progress |
| stat_mst_en | output | 1 | Master mode currently on |
| stat_done | output | 1 | Sticky exchange-complete flag |
| stat_coll | output | 1 | Sticky write collision flag |
| stat_ovr | output | 1 | Sticky receive overrun flag |
| stat_fault | output | 1 | Sticky mode fault flag |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sel_n | input | 1 | Select input for fault detection |

## Verification
Errors in the edge counter or the divider show up in the length of the busy window. That window is measured to the cycle on every exchange, so any such error appears when the first exchange ends. A wrong phase or shift order corrupts both the word a modelled slave collects and `rx_data`, and this is visible when the exchange ends. Wrong flag logic shows at the status pins one cycle after the event that should set or clear the flag. A fault that fails to abort shows as `stat_busy` still high on the cycle after `sel_n` goes low.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef struct packed {
        logic mst_en;
        logic cpol;
        logic cpha;
        logic wide;
        logic fault_en;
        logic irq_en;
    } spim_cfg_t;

    // bit 0 done, bit 1 collision, bit 2 overrun, bit 3 fault
    typedef struct packed {
        logic fault;
        logic ovr;
        logic coll;
        logic done;
    } spim_flags_t;

    localparam int unsigned FLAG_N = 4;

endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } baud_st_t;

    baud_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (!run) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == div) begin
            st_d.cnt = '0;
            tick     = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (div != '0) |=> !tick || !$stable(div)); // R2

endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned SHORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              tick,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              wide,
    input  logic [DATA_W-1:0] load_word,
    input  logic              miso,
    output logic              busy,
    output logic              done_ev,
    output logic              sck,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_word
);

    localparam int unsigned CNT_W = $clog2(2 * DATA_W);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(2 * DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(2 * SHORT_W - 1);
    localparam logic [DATA_W-1:0] SHORT_MASK = {{(DATA_W - SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

    typedef struct packed {
        logic              busy;
        logic              cpha_l;
        logic              wide_l;
        logic              sck;
        logic              smp;
        logic              mosi_r;
        logic [CNT_W-1:0]  edge_cnt;
        logic [DATA_W-1:0] sreg;
        logic [DATA_W-1:0] rx;
    } shift_st_t;

    shift_st_t st_d, st_q;

    logic              out_msb;
    logic              last_edge;
    logic              leading;
    logic              in_bit;
    logic [DATA_W-1:0] shifted;

    assign out_msb   = st_q.wide_l ? st_q.sreg[DATA_W-1] : st_q.sreg[SHORT_W-1];
    assign last_edge = st_q.edge_cnt == (st_q.wide_l ? LAST_LONG : LAST_SHORT);
    assign leading   = ~st_q.edge_cnt[0];
    assign in_bit    = st_q.cpha_l ? miso : st_q.smp;
    assign shifted   = {st_q.sreg[DATA_W-2:0], in_bit};

    always_comb begin
        st_d    = st_q;
        done_ev = 1'b0;
        if (abort) begin
            st_d.busy     = 1'b0;
            st_d.sck      = cpol;
            st_d.edge_cnt = '0;
        end else if (start) begin
            st_d.busy     = 1'b1;
            st_d.cpha_l   = cpha;
            st_d.wide_l   = wide;
            st_d.sck      = cpol;
            st_d.edge_cnt = '0;
            st_d.sreg     = load_word;
            st_d.mosi_r   = wide ? load_word[DATA_W-1] : load_word[SHORT_W-1];
        end else if (st_q.busy) begin
            if (tick) begin
                st_d.sck      = ~st_q.sck;
                st_d.edge_cnt = st_q.edge_cnt + 1'b1;
                if (leading) begin
                    if (st_q.cpha_l) st_d.mosi_r = out_msb;
                    else             st_d.smp    = miso;
                end else begin
                    st_d.sreg = shifted;
                    if (last_edge) begin
                        st_d.busy     = 1'b0;
                        st_d.edge_cnt = '0;
                        st_d.rx       = st_q.wide_l ? shifted : (shifted & SHORT_MASK);
                        done_ev       = 1'b1;
                    end
                end
            end
        end else begin
            st_d.sck = cpol;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign sck     = st_q.sck;
    assign mosi    = st_q.cpha_l ? st_q.mosi_r : out_msb;
    assign rx_word = st_q.rx;

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start && !abort |=> st_q.busy); // R1
    AST_EDGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> st_q.edge_cnt <= (st_q.wide_l ? LAST_LONG : LAST_SHORT)); // R2
    AST_RX_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |=> $stable(st_q.rx)); // R3
    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !st_q.busy && $stable(st_q.rx)); // R9

endmodule

// File: rtl/spim_regs.sv
module spim_regs
    import spim_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  spim_cfg_t         cfg_in,
    input  logic [DIV_W-1:0]  div_in,
    input  logic              clr_wr,
    input  logic [FLAG_N-1:0] clr_mask,
    input  logic              data_wr,
    input  logic              busy,
    input  logic              done_ev,
    input  logic              sel_n,
    output spim_cfg_t         cfg,
    output logic [DIV_W-1:0]  div,
    output spim_flags_t       flags,
    output logic              start,
    output logic              fault,
    output logic              irq
);

    typedef struct packed {
        spim_cfg_t        cfg;
        logic [DIV_W-1:0] div;
        spim_flags_t      flags;
    } regs_st_t;

    regs_st_t st_d, st_q;
    logic     coll_ev;

    assign fault   = st_q.cfg.fault_en & st_q.cfg.mst_en & ~sel_n;
    assign start   = data_wr & st_q.cfg.mst_en & ~busy & ~fault;
    assign coll_ev = data_wr & busy;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.cfg = cfg_in;
            st_d.div = div_in;
        end
        if (fault) st_d.cfg.mst_en = 1'b0;
        if (clr_wr) st_d.flags = spim_flags_t'(st_q.flags & ~clr_mask);
        if (done_ev) begin
            st_d.flags.done = 1'b1;
            if (st_q.flags.done) st_d.flags.ovr = 1'b1;
        end
        if (coll_ev) st_d.flags.coll  = 1'b1;
        if (fault)   st_d.flags.fault = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg   = st_q.cfg;
    assign div   = st_q.div;
    assign flags = st_q.flags;
    assign irq   = st_q.cfg.irq_en & (|st_q.flags);

    AST_COLL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && busy |=> st_q.flags.coll); // R5
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flags.done && !(clr_wr && clr_mask[0]) |=> st_q.flags.done); // R4
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        done_ev && st_q.flags.done |=> st_q.flags.ovr); // R6
    AST_FAULT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !st_q.cfg.mst_en && st_q.flags.fault); // R9
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.cfg.irq_en |-> !irq); // R7

endmodule

// File: rtl/spi_ctl_master.sv
module spi_ctl_master
    import spim_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned SHORT_W = 8,
    parameter int unsigned DIV_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_mst_en,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_wide,
    input  logic              cfg_fault_en,
    input  logic              cfg_irq_en,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              clr_wr,
    input  logic [FLAG_N-1:0] clr_mask,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] rx_data,
    output logic              stat_busy,
    output logic              stat_mst_en,
    output logic              stat_done,
    output logic              stat_coll,
    output logic              stat_ovr,
    output logic              stat_fault,
    output logic              irq,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    input  logic              sel_n
);

    spim_cfg_t        cfg_in, cfg;
    spim_flags_t      flags;
    logic [DIV_W-1:0] div;
    logic             start, fault, tick, busy, done_ev;

    assign cfg_in = '{mst_en: cfg_mst_en, cpol: cfg_cpol, cpha: cfg_cpha,
                      wide: cfg_wide, fault_en: cfg_fault_en, irq_en: cfg_irq_en};

    spim_regs #(.DIV_W(DIV_W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_in   (cfg_in),
        .div_in   (cfg_div),
        .clr_wr   (clr_wr),
        .clr_mask (clr_mask),
        .data_wr  (data_wr),
        .busy     (busy),
        .done_ev  (done_ev),
        .sel_n    (sel_n),
        .cfg      (cfg),
        .div      (div),
        .flags    (flags),
        .start    (start),
        .fault    (fault),
        .irq      (irq)
    );

    spim_baud #(.DIV_W(DIV_W)) i_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (div),
        .tick  (tick)
    );

    spim_shift #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .abort     (fault),
        .tick      (tick),
        .cpol      (cfg.cpol),
        .cpha      (cfg.cpha),
        .wide      (cfg.wide),
        .load_word (data_in),
        .miso      (miso),
        .busy      (busy),
        .done_ev   (done_ev),
        .sck       (sck),
        .mosi      (mosi),
        .rx_word   (rx_data)
    );

    assign stat_busy   = busy;
    assign stat_mst_en = cfg.mst_en;
    assign stat_done   = flags.done;
    assign stat_coll   = flags.coll;
    assign stat_ovr    = flags.ovr;
    assign stat_fault  = flags.fault;

    AST_IDLE_WRITE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && !cfg.mst_en && !busy |=> !busy && $stable(flags)); // R10

endmodule

// File: tb/test_spi_ctl_master.sv
module test_spi_ctl_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 0, cfg_mst_en = 0, cfg_cpol = 0, cfg_cpha = 0, cfg_wide = 0;
    logic        cfg_fault_en = 0, cfg_irq_en = 0;
    logic [7:0]  cfg_div = 0;
    logic        clr_wr = 0;
    logic [3:0]  clr_mask = 0;
    logic        data_wr = 0;
    logic [15:0] data_in = 0;
    logic [15:0] rx_data;
    logic        stat_busy, stat_mst_en, stat_done, stat_coll, stat_ovr, stat_fault, irq;
    logic        sck, mosi, miso;
    logic        sel_n = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // slave model state
    bit          tb_cpol = 0, tb_cpha = 0, tb_wide = 0, slv_on = 0;
    logic [15:0] s_tx = 0, s_rx = 0;

    always #10 clk = ~clk;

    spi_ctl_master i_spi_ctl_master (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mst_en(cfg_mst_en),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_wide(cfg_wide),
        .cfg_fault_en(cfg_fault_en), .cfg_irq_en(cfg_irq_en), .cfg_div(cfg_div),
        .clr_wr(clr_wr), .clr_mask(clr_mask), .data_wr(data_wr), .data_in(data_in),
        .rx_data(rx_data), .stat_busy(stat_busy), .stat_mst_en(stat_mst_en),
        .stat_done(stat_done), .stat_coll(stat_coll), .stat_ovr(stat_ovr),
        .stat_fault(stat_fault), .irq(irq), .sck(sck), .mosi(mosi), .miso(miso),
        .sel_n(sel_n)
    );

    assign miso = tb_wide ? s_tx[15] : s_tx[7];

    always @(sck) begin
        if (slv_on) begin
            if ((sck != tb_cpol) ^ tb_cpha) s_rx = {s_rx[14:0], mosi};
            if (sck == tb_cpol) s_tx = s_tx << 1;
        end
    end

    function automatic logic [15:0] fit(input logic [15:0] w, input bit wide);
        return wide ? w : {8'h00, w[7:0]};
    endfunction

    function automatic int span(input bit wide, input int d);
        return 2 * (wide ? 16 : 8) * (d + 1);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input bit mst, input bit cpol, input bit cpha, input bit wide,
                           input bit fen, input bit ien, input logic [7:0] d);
        @(negedge clk);
        cfg_mst_en = mst; cfg_cpol = cpol; cfg_cpha = cpha; cfg_wide = wide;
        cfg_fault_en = fen; cfg_irq_en = ien; cfg_div = d; cfg_wr = 1;
        @(negedge clk);
        cfg_wr = 0;
        @(negedge clk);
        tb_cpol = cpol; tb_cpha = cpha; tb_wide = wide;
    endtask

    task automatic clear(input logic [3:0] m);
        @(negedge clk);
        clr_mask = m; clr_wr = 1;
        @(negedge clk);
        clr_wr = 0;
    endtask

    task automatic launch(input logic [15:0] tx, input logic [15:0] sw);
        s_tx = sw; s_rx = 0; slv_on = 1;
        data_in = tx; data_wr = 1;
        @(negedge clk);
        data_wr = 0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (stat_busy && cyc < 20000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic full_xfer(input logic [15:0] tx, input logic [15:0] sw, input bit wide, input int d);
        int c;
        launch(tx, sw);
        check("R1 busy after write", stat_busy, 1);
        wait_idle(c);
        check("R2 busy length", c, span(wide, d));
        check("R3 R8 rx_data", rx_data, fit(sw, wide));
        check("R3 R8 mosi order at slave", fit(s_rx, wide), fit(tx, wide));
        check("R4 done set", stat_done, 1);
    endtask

    initial begin
        int c;
        logic [15:0] keep;
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        check("R11 busy", stat_busy, 0);
        check("R11 mst_en", stat_mst_en, 0);
        check("R11 flags", {stat_fault, stat_ovr, stat_coll, stat_done}, 0);
        check("R11 irq", irq, 0);
        check("R11 sck", sck, 0);
        check("R11 rx_data", rx_data, 0);

        // R10 write while master off
        launch(16'hA5A5, 16'h0);
        check("R10 no busy", stat_busy, 0);
        @(negedge clk);
        check("R10 no flags", {stat_fault, stat_ovr, stat_coll, stat_done}, 0);

        // R8 idle level follows cpol
        set_cfg(1, 1, 0, 0, 0, 0, 8'd0);
        check("R8 idle sck high", sck, 1);
        set_cfg(1, 0, 0, 0, 0, 0, 8'd0);
        check("R8 idle sck low", sck, 0);

        // random transfers over all modes
        for (int i = 0; i < 24; i++) begin
            bit pol, pha, wd;
            int d;
            pol = 1'($urandom); pha = 1'($urandom); wd = 1'($urandom);
            d = $urandom % 4;
            clear(4'hF);
            set_cfg(1, pol, pha, wd, 0, 0, 8'(d));
            full_xfer(16'($urandom), 16'($urandom), wd, d);
        end

        // R2 largest divider, 8-bit
        clear(4'hF);
        set_cfg(1, 0, 1, 0, 0, 0, 8'd255);
        full_xfer(16'h003C, 16'h00C3, 0, 255);

        // R5 collision during a transfer
        clear(4'hF);
        set_cfg(1, 0, 0, 1, 0, 0, 8'd2);
        launch(16'hBEEF, 16'h1234);
        repeat (4) @(negedge clk);
        data_in = 16'h0F0F; data_wr = 1;
        @(negedge clk);
        data_wr = 0;
        check("R5 coll set", stat_coll, 1);
        check("R5 still busy", stat_busy, 1);
        wait_idle(c);
        check("R5 length unchanged", c, span(1, 2) - 5);
        check("R5 rx unchanged", rx_data, 16'h1234);
        check("R5 mosi unchanged", s_rx, 16'hBEEF);

        // R12 masked clear keeps done
        clear(4'b0010);
        check("R12 coll cleared", stat_coll, 0);
        check("R12 done kept", stat_done, 1);

        // R6 overrun
        full_xfer(16'h5555, 16'h9ABC, 1, 2);
        check("R6 ovr set", stat_ovr, 1);
        check("R6 rx overwritten", rx_data, 16'h9ABC);

        // R7 interrupt gating
        check("R7 irq off when disabled", irq, 0);
        set_cfg(1, 0, 0, 1, 0, 1, 8'd2);
        check("R7 irq on", irq, 1);
        clear(4'hF);
        check("R7 irq off after clear", irq, 0);

        // R9 mode fault aborts
        set_cfg(1, 1, 0, 1, 1, 1, 8'd3);
        keep = rx_data;
        launch(16'h7777, 16'h4321);
        repeat (6) @(negedge clk);
        sel_n = 0;
        @(negedge clk);
        sel_n = 1;
        check("R9 busy dropped", stat_busy, 0);
        check("R9 fault set", stat_fault, 1);
        check("R9 master off", stat_mst_en, 0);
        check("R9 sck idle", sck, 1);
        check("R9 rx unchanged", rx_data, keep);
        check("R9 done not set", stat_done, 0);
        check("R7 irq from fault", irq, 1);
        launch(16'h1111, 16'h0);
        check("R10 no start after fault", stat_busy, 0);

        // R9 fault detection disabled
        clear(4'hF);
        set_cfg(1, 0, 1, 1, 0, 0, 8'd1);
        sel_n = 0;
        full_xfer(16'hC001, 16'hD00D, 1, 1);
        check("R9 no fault when disabled", stat_fault, 0);
        sel_n = 1;

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule